// File: doc/BRIEF.md
# Bit-6 Channel Swizzle Unit

This block rewrites bit 6 of a tiled-surface byte address so that it matches the channel interleave of a dual-channel memory system. Bit 6 is XORed with the parity of a selected set of higher address bits (9, 10, 11 and 17). The set comes from a swizzle mode. X-tiled surfaces use one mode register and Y-tiled surfaces use the other. Linear accesses always pass through unchanged.

A small decode front end works out both modes from memory-channel configuration inputs. These are a configuration word (channel arrangement, channel-XOR disable, high-bit select) and, as an alternative method, two channel size fields that are compared with each other. The decode is captured into the mode registers only on a load strobe. A configuration the decode cannot resolve, or a word read back as all ones, leaves both modes at "none" and raises a pin-pages flag. Software then knows that page placement must not change.

The address path is a combinational stream stage. `out_valid` follows `in_valid`, and `in_ready` follows `out_ready`, in the same cycle. Back-pressure from the consumer therefore passes straight to the producer. A beat is transferred on a cycle where valid and ready are both high. The address must be held while valid is high and ready is low.

Top module: `swz_bit6_unit`

## Requirements
- R1: Every address bit except bit 6 passes unchanged. Bit 6 is XORed with the parity of the bits chosen by the active mode. Mode codes: 0 none, 1 {9}, 2 {9,10}, 3 {9,11}, 4 {9,10,11}, 5 {9,17}, 6 {9,10,17}.
- R2: Tile code 0 (linear) and the reserved code 3 leave the address unchanged, whatever the modes.
- R3: Tile code 1 (X) uses `mode_x`. Tile code 2 (Y) uses `mode_y`.
- R4: With the word method (`cfg_by_size`=0), a channel field `cfg_word[1:0]` of 0 (single) or 1 (asymmetric dual) loads both modes as 0 and clears the pin flag.
- R5: Channel field 2 (interleaved) with `cfg_word[2]`=1 (channel XOR disabled) loads X=2 and Y=1.
- R6: Channel field 2 with `cfg_word[2]`=0 loads X=4 and Y=3 when `cfg_word[3]`=0 (bit 11). It loads X=6 and Y=5 when `cfg_word[3]`=1 (bit 17).
- R7: With the size method (`cfg_by_size`=1), equal `cfg_size_a` and `cfg_size_b` load X=2 and Y=1. Different sizes load 0 and 0. In both cases the pin flag clears.
- R8: Channel field 3 (unknown), or a `cfg_word` of all ones under either method, loads both modes as 0 and sets `pin_pages`.
- R9: After reset the modes are 0 and `pin_pages` is 0. Modes and the flag change only on the edge where `cfg_load` is high. Configuration inputs have no effect at any other time.
- R10: `out_valid` equals `in_valid`, and `in_ready` equals `out_ready`, combinationally.
- R11: A Y mode never includes bit 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Address beat valid |
| in_ready | output | 1 | Unit can accept a beat |
| in_addr | input | ADDR_W | Byte address |
| in_tile | input | 2 | Tiling: 0 linear, 1 X, 2 Y, 3 reserved |
| out_valid | output | 1 | Swizzled beat valid |
| out_ready | input | 1 | Consumer accepts beat |
| out_addr | output | ADDR_W | Swizzled byte address |
| cfg_load | input | 1 | Capture the decoded modes |
| cfg_by_size | input | 1 | 1: size-compare method, 0: word method |
| cfg_word | input | CFG_W | Configuration word (fields in R4 to R6) |
| cfg_size_a | input | SIZE_W | Populated size, channel A |
| cfg_size_b | input | SIZE_W | Populated size, channel B |
| mode_x | output | 3 | Active X-tile mode code |
| mode_y | output | 3 | Active Y-tile mode code |
| pin_pages | output | 1 | Configuration unresolved; pin pages |

## Verification
The address and handshake results come out in the same cycle. The bench drives them after a falling edge and samples them 1 ns later, with no clock edge in between. Mode and flag results are due one rising edge after `cfg_load` is sampled high. The bench raises the strobe at a falling edge, lets exactly one rising edge pass, drops it at the next falling edge and reads the modes there. Changes to the configuration inputs with the strobe low are checked across several edges to show the modes do not move.

// File: rtl/swz_pkg.sv
package swz_pkg;

  typedef enum logic [2:0] {
    SWZ_NONE     = 3'd0,
    SWZ_9        = 3'd1,
    SWZ_9_10     = 3'd2,
    SWZ_9_11     = 3'd3,
    SWZ_9_10_11  = 3'd4,
    SWZ_9_17     = 3'd5,
    SWZ_9_10_17  = 3'd6
  } swz_mode_e;

  typedef enum logic [1:0] {
    TILE_LIN = 2'd0,
    TILE_X   = 2'd1,
    TILE_Y   = 2'd2,
    TILE_RSV = 2'd3
  } tile_e;

  typedef enum logic [1:0] {
    CHAN_SINGLE = 2'd0,
    CHAN_ASYM   = 2'd1,
    CHAN_INTLV  = 2'd2,
    CHAN_UNK    = 2'd3
  } chan_e;

  // configuration word field positions
  localparam int CFG_CHAN_LSB = 0;
  localparam int CFG_XOFF_BIT = 2;
  localparam int CFG_HI17_BIT = 3;

  // candidate source bits XORed into bit 6
  localparam int NUM_TAPS = 4;
  localparam int TAP_POS [NUM_TAPS] = '{9, 10, 11, 17};
  localparam int TARGET_BIT = 6;

  // tap mask, bit i selects TAP_POS[i]
  function automatic logic [NUM_TAPS-1:0] tap_mask(input swz_mode_e m);
    case (m)
      SWZ_9:       tap_mask = 4'b0001;
      SWZ_9_10:    tap_mask = 4'b0011;
      SWZ_9_11:    tap_mask = 4'b0101;
      SWZ_9_10_11: tap_mask = 4'b0111;
      SWZ_9_17:    tap_mask = 4'b1001;
      SWZ_9_10_17: tap_mask = 4'b1011;
      default:     tap_mask = 4'b0000;
    endcase
  endfunction

endpackage

// File: rtl/swz_mode_decode.sv
module swz_mode_decode
  import swz_pkg::*;
#(
  parameter int CFG_W  = 32,
  parameter int SIZE_W = 8
) (
  input  logic              by_size,
  input  logic [CFG_W-1:0]  word,
  input  logic [SIZE_W-1:0] size_a,
  input  logic [SIZE_W-1:0] size_b,
  output swz_mode_e         dec_x,
  output swz_mode_e         dec_y,
  output logic              dec_pin
);
  chan_e chan;
  logic  xor_off;
  logic  hi17;
  logic  unresolved;

  assign chan    = chan_e'(word[CFG_CHAN_LSB +: 2]);
  assign xor_off = word[CFG_XOFF_BIT];
  assign hi17    = word[CFG_HI17_BIT];

  always_comb begin
    unresolved = 1'b0;
    dec_x      = SWZ_NONE;
    dec_y      = SWZ_NONE;
    if (&word) begin
      unresolved = 1'b1;
    end else if (by_size) begin
      if (size_a == size_b) begin
        dec_x = SWZ_9_10;
        dec_y = SWZ_9;
      end
    end else begin
      case (chan)
        CHAN_SINGLE, CHAN_ASYM: begin
          dec_x = SWZ_NONE;
          dec_y = SWZ_NONE;
        end
        CHAN_INTLV: begin
          if (xor_off) begin
            dec_x = SWZ_9_10;
            dec_y = SWZ_9;
          end else if (hi17) begin
            dec_x = SWZ_9_10_17;
            dec_y = SWZ_9_17;
          end else begin
            dec_x = SWZ_9_10_11;
            dec_y = SWZ_9_11;
          end
        end
        default: unresolved = 1'b1;
      endcase
    end
    if (unresolved) begin
      dec_x = SWZ_NONE;
      dec_y = SWZ_NONE;
    end
    dec_pin = unresolved;
  end
endmodule

// File: rtl/swz_mode_regs.sv
module swz_mode_regs
  import swz_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  swz_mode_e nxt_x,
  input  swz_mode_e nxt_y,
  input  logic      nxt_pin,
  output swz_mode_e cur_x,
  output swz_mode_e cur_y,
  output logic      cur_pin
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_x   <= SWZ_NONE;
      cur_y   <= SWZ_NONE;
      cur_pin <= 1'b0;
    end else if (load) begin
      cur_x   <= nxt_x;
      cur_y   <= nxt_y;
      cur_pin <= nxt_pin;
    end
  end
endmodule

// File: rtl/swz_bit6_xor.sv
module swz_bit6_xor
  import swz_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  tile_e             tile,
  input  swz_mode_e         mode_x,
  input  swz_mode_e         mode_y,
  output logic [ADDR_W-1:0] addr_o
);
  swz_mode_e           sel_mode;
  logic [NUM_TAPS-1:0] mask;
  logic [NUM_TAPS-1:0] tap_bits;
  logic                flip;

  always_comb begin
    case (tile)
      TILE_X:  sel_mode = mode_x;
      TILE_Y:  sel_mode = mode_y;
      default: sel_mode = SWZ_NONE;
    endcase
  end

  assign mask = tap_mask(sel_mode);

  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
    assign tap_bits[i] = addr_i[TAP_POS[i]] & mask[i];
  end

  assign flip = ^tap_bits;

  always_comb begin
    addr_o             = addr_i;
    addr_o[TARGET_BIT] = addr_i[TARGET_BIT] ^ flip;
  end
endmodule

// File: rtl/swz_bit6_unit.sv
module swz_bit6_unit
  import swz_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CFG_W  = 32,
  parameter int SIZE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [1:0]        in_tile,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  input  logic              cfg_load,
  input  logic              cfg_by_size,
  input  logic [CFG_W-1:0]  cfg_word,
  input  logic [SIZE_W-1:0] cfg_size_a,
  input  logic [SIZE_W-1:0] cfg_size_b,
  output logic [2:0]        mode_x,
  output logic [2:0]        mode_y,
  output logic              pin_pages
);
  swz_mode_e dec_x, dec_y, cur_x, cur_y;
  logic      dec_pin;

  swz_mode_decode #(.CFG_W(CFG_W), .SIZE_W(SIZE_W)) u_dec (
    .by_size (cfg_by_size),
    .word    (cfg_word),
    .size_a  (cfg_size_a),
    .size_b  (cfg_size_b),
    .dec_x   (dec_x),
    .dec_y   (dec_y),
    .dec_pin (dec_pin)
  );

  swz_mode_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (cfg_load),
    .nxt_x   (dec_x),
    .nxt_y   (dec_y),
    .nxt_pin (dec_pin),
    .cur_x   (cur_x),
    .cur_y   (cur_y),
    .cur_pin (pin_pages)
  );

  swz_bit6_xor #(.ADDR_W(ADDR_W)) u_xor (
    .addr_i (in_addr),
    .tile   (tile_e'(in_tile)),
    .mode_x (cur_x),
    .mode_y (cur_y),
    .addr_o (out_addr)
  );

  assign mode_x    = cur_x;
  assign mode_y    = cur_y;
  assign out_valid = in_valid;
  assign in_ready  = out_ready;
endmodule

// File: rtl/swz_bit6_chk.sv
module swz_bit6_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [ADDR_W-1:0] in_addr,
  input logic [1:0]        in_tile,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_addr,
  input logic              cfg_load,
  input logic [2:0]        mode_x,
  input logic [2:0]        mode_y,
  input logic              pin_pages
);
  logic [ADDR_W-1:0] keep_mask;
  always_comb begin
    keep_mask    = '1;
    keep_mask[6] = 1'b0;
  end

  // R1
  upper_bits_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_addr ^ in_addr) & keep_mask) == '0);

  // R2
  linear_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_tile == 2'd0 || in_tile == 2'd3) |-> out_addr == in_addr);

  // R8
  pin_forces_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_pages |-> (mode_x == 3'd0 && mode_y == 3'd0));

  // R9
  hold_without_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> ($stable(mode_x) && $stable(mode_y) && $stable(pin_pages)));

  // R10
  stream_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid == in_valid) && (in_ready == out_ready));

  // R11
  y_lacks_bit10_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_y == 3'd0 || mode_y == 3'd1 || mode_y == 3'd3 || mode_y == 3'd5));
endmodule

bind swz_bit6_unit swz_bit6_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_addr   (in_addr),
  .in_tile   (in_tile),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_addr  (out_addr),
  .cfg_load  (cfg_load),
  .mode_x    (mode_x),
  .mode_y    (mode_y),
  .pin_pages (pin_pages)
);

// File: tb/tb_swz_bit6_unit.sv
`timescale 1ns/1ps
module tb_swz_bit6_unit;
  localparam int ADDR_W = 32;
  localparam int CFG_W  = 32;
  localparam int SIZE_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0, out_ready = 1'b0;
  logic              in_ready, out_valid;
  logic [ADDR_W-1:0] in_addr = '0, out_addr;
  logic [1:0]        in_tile = 2'd0;
  logic              cfg_load = 1'b0, cfg_by_size = 1'b0;
  logic [CFG_W-1:0]  cfg_word = '0;
  logic [SIZE_W-1:0] cfg_size_a = '0, cfg_size_b = '0;
  logic [2:0]        mode_x, mode_y;
  logic              pin_pages;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  swz_bit6_unit #(.ADDR_W(ADDR_W), .CFG_W(CFG_W), .SIZE_W(SIZE_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr), .in_tile(in_tile),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .cfg_load(cfg_load), .cfg_by_size(cfg_by_size), .cfg_word(cfg_word),
    .cfg_size_a(cfg_size_a), .cfg_size_b(cfg_size_b),
    .mode_x(mode_x), .mode_y(mode_y), .pin_pages(pin_pages)
  );

  function automatic logic [ADDR_W-1:0] ref_swz(input logic [ADDR_W-1:0] a, input int m);
    logic b;
    case (m)
      1: b = a[9];
      2: b = a[9] ^ a[10];
      3: b = a[9] ^ a[11];
      4: b = a[9] ^ a[10] ^ a[11];
      5: b = a[9] ^ a[17];
      6: b = a[9] ^ a[10] ^ a[17];
      default: b = 1'b0;
    endcase
    ref_swz = a;
    ref_swz[6] = a[6] ^ b;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load_cfg(input logic by_size, input logic [CFG_W-1:0] w,
                          input logic [SIZE_W-1:0] sa, input logic [SIZE_W-1:0] sb);
    @(negedge clk);
    cfg_by_size = by_size; cfg_word = w; cfg_size_a = sa; cfg_size_b = sb;
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic check_modes(input string req, input int ex, input int ey, input int ep);
    check(req, mode_x, ex);
    check(req, mode_y, ey);
    check(req, pin_pages, ep);
  endtask

  logic [ADDR_W-1:0] pats [6] = '{32'h0000_0200, 32'h0000_0600, 32'h0002_0800,
                                  32'h0000_0440, 32'hFFFF_FFBF, 32'h1357_9ACE};

  task automatic sweep_addrs(input string req, input int mx, input int my);
    for (int i = 0; i < 6; i++) begin
      for (int t = 0; t < 4; t++) begin
        @(negedge clk);
        in_addr = pats[i]; in_tile = t[1:0];
        #1;
        case (t)
          1: check(req, out_addr, ref_swz(pats[i], mx));
          2: check(req, out_addr, ref_swz(pats[i], my));
          default: check("R2", out_addr, pats[i]);
        endcase
      end
    end
  endtask

  task automatic t_reset;
    check_modes("R9 reset", 0, 0, 0);
    sweep_addrs("R1 none", 0, 0);
  endtask

  task automatic t_single_asym;
    load_cfg(1'b0, 32'h0, 8'd0, 8'd0);
    check_modes("R4 single", 0, 0, 0);
    load_cfg(1'b0, 32'h1, 8'd0, 8'd0);
    check_modes("R4 asym", 0, 0, 0);
  endtask

  task automatic t_intlv;
    load_cfg(1'b0, 32'h6, 8'd0, 8'd0);
    check_modes("R5 xor off", 2, 1, 0);
    sweep_addrs("R3 R5", 2, 1);
    load_cfg(1'b0, 32'h2, 8'd0, 8'd0);
    check_modes("R6 bit11", 4, 3, 0);
    sweep_addrs("R6 bit11 addr", 4, 3);
    load_cfg(1'b0, 32'hA, 8'd0, 8'd0);
    check_modes("R6 bit17", 6, 5, 0);
    sweep_addrs("R6 bit17 addr", 6, 5);
  endtask

  task automatic t_size;
    load_cfg(1'b1, 32'h3, 8'd40, 8'd40);
    check_modes("R7 equal", 2, 1, 0);
    load_cfg(1'b1, 32'h2, 8'd40, 8'd41);
    check_modes("R7 differ", 0, 0, 0);
  endtask

  task automatic t_unknown;
    load_cfg(1'b0, 32'hA, 8'd0, 8'd0);
    load_cfg(1'b0, 32'h3, 8'd0, 8'd0);
    check_modes("R8 chan unknown", 0, 0, 1);
    sweep_addrs("R8 addr", 0, 0);
    load_cfg(1'b0, 32'h6, 8'd0, 8'd0);
    check_modes("R8 clears", 2, 1, 0);
    load_cfg(1'b1, 32'hFFFF_FFFF, 8'd5, 8'd5);
    check_modes("R8 all ones", 0, 0, 1);
  endtask

  task automatic t_no_load;
    load_cfg(1'b0, 32'h2, 8'd0, 8'd0);
    @(negedge clk);
    cfg_word = 32'h3; cfg_by_size = 1'b1; cfg_size_a = 8'd1; cfg_size_b = 8'd2;
    repeat (3) @(negedge clk);
    check_modes("R9 ignored", 4, 3, 0);
    in_addr = 32'h0000_0800; in_tile = 2'd1;
    #1;
    check("R9 ignored addr", out_addr, 32'h0000_0840);
  endtask

  task automatic t_stream;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      in_valid = k[0]; out_ready = k[1];
      #1;
      check("R10 valid", out_valid, k[0]);
      check("R10 ready", in_ready, k[1]);
    end
  endtask

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_asym();
    t_intlv();
    t_size();
    t_unknown();
    t_no_load();
    t_stream();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule